// File: doc/BRIEF.md
# Protected Configuration Register Bank

This block holds a few configuration registers that set up the basic behaviour of a small 8-bit controller. Any mistaken write to them could disturb the whole system, so writes are restricted. After any reset, a protected register takes writes only during a fixed opening window of bus cycles. Two of the three protected registers also accept only one write per reset. A strap input selects a test mode. In that mode both restrictions are lifted, so a test program can rewrite the registers as often as it needs. Software leaves test mode for good by clearing a mode bit. From then on, the normal rules govern every later write.

One protected register is the memory map. Its high nibble chooses the 4 KiB page that holds the internal RAM, and its low nibble chooses the page that holds the register block. The block compares the bus address with both nibbles and drives a RAM select and a register select. When the two areas overlap, the register select wins.

Each clock edge counts as one bus cycle. The configuration port is a simple select/write-enable/address/data interface. Read data is combinational.

Top module: `prot_cfg_bank`

## Requirements
- R1: After reset the registers read as follows: slot 0 (map) reads 0x01, slot 1 (timer control) reads 0x00 and slot 2 (options) reads 0x10. Slot 3 (mode) reads bit 0 equal to `special_strap_i` and its other bits as zero. `win_closed_o` is low.
- R2: The window rule applies outside test mode. A write to slot 0, 1 or 2 takes effect on clock edges 0 to WINDOW-1 after reset release, where edge 0 is the first edge. From edge WINDOW onward such a write is ignored. `win_closed_o` rises after edge WINDOW-1 and stays high until the next reset.
- R3: Slots 0 and 1 are write-once. After their first accepted write, any later write outside test mode is ignored, even inside the window. Slot 2 may be rewritten as often as needed while the window is open.
- R4: While `special_o` is high, writes to slots 0, 1 and 2 always take effect, whatever the cycle count and whatever writes came before.
- R5: Writing slot 3 with bit 0 = 0 drops `special_o` low until the next reset. Writing bit 0 = 1 has no effect. From the next write onward, the window and write-once rules apply, and a write accepted in test mode still counts as the first write.
- R6: Only bits 3:0 of slot 1 are implemented. Bits 7:4 are never stored and always read 0.
- R7: `ram_sel_o` is high when `bus_addr_i[15:12]` equals map bits 7:4 and `bus_addr_i[11:0]` is less than RAM_BYTES (256).
- R8: `reg_sel_o` is high when `bus_addr_i[15:12]` equals map bits 3:0 and `bus_addr_i[11:0]` is less than REG_BYTES (64).
- R9: When both decode conditions hold, `reg_sel_o` is high and `ram_sel_o` is low.
- R10: `cfg_rdata_o` shows, combinationally, the slot chosen by `cfg_addr_i`, with the encoding 0 = map, 1 = timer control, 2 = options, 3 = mode. The `cfg_sel_i` input gates only writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge is one bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_strap_i | input | 1 | Test-mode strap, held stable outside reset |
| cfg_sel_i | input | 1 | Configuration access strobe |
| cfg_we_i | input | 1 | Write enable for the configuration access |
| cfg_addr_i | input | 2 | Slot index |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Read data of the selected slot |
| bus_addr_i | input | ADDR_W | System address to decode |
| ram_sel_o | output | 1 | Internal RAM select |
| reg_sel_o | output | 1 | Register block select |
| special_o | output | 1 | Test mode currently active |
| win_closed_o | output | 1 | Write window has expired |

## Verification
A write that is accepted on edge n appears on `cfg_rdata_o` one register stage later, so the bench reads it back at the falling edge after n. Decode outputs and read data are combinational. They are checked a short delay after the address is driven, with no clock edge in between. The bench keeps its own count of edges since reset release and drives each timed write on the falling edge just before the edge it means. This places the last open-window write exactly on edge 63 and the first rejected one on edge 64. `win_closed_o` is sampled at the falling edges before and after edge 63.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_PROT = 3;
  localparam int SEL_W    = 2;
  localparam int PAGE_W   = 4;

  typedef logic [DATA_W-1:0] cfg_byte_t;

  localparam logic [SEL_W-1:0] SLOT_MAP  = 2'd0;
  localparam logic [SEL_W-1:0] SLOT_TCTL = 2'd1;
  localparam logic [SEL_W-1:0] SLOT_OPT  = 2'd2;
  localparam logic [SEL_W-1:0] SLOT_MODE = 2'd3;

  // per protected slot: reset value, implemented bits, write-once
  localparam cfg_byte_t PROT_RST  [NUM_PROT] = '{8'h01, 8'h00, 8'h10};
  localparam cfg_byte_t PROT_IMPL [NUM_PROT] = '{8'hFF, 8'h0F, 8'hFF};
  localparam logic [NUM_PROT-1:0] PROT_ONCE = 3'b011;
endpackage

// File: rtl/pcb_cycle_window.sv
module pcb_cycle_window #(
  parameter int WINDOW = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic open_o
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WINDOW);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // saturating count of bus cycles since reset release
  always_comb begin
    cnt_en = (cnt_q != LIMIT);
    cnt_d  = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign open_o = cnt_en;
endmodule

// File: rtl/pcb_prot_reg.sv
module pcb_prot_reg #(
  parameter int             W    = 8,
  parameter logic [W-1:0]   RST  = '0,
  parameter logic [W-1:0]   IMPL = '1,
  parameter bit             ONCE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic         window_open_i,
  input  logic         special_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o,
  output logic         locked_o
);
  logic [W-1:0] val_q, val_d;
  logic         lock_q;
  logic         accept;
  logic         blocked;

  always_comb begin
    blocked = ONCE & lock_q;
    accept  = wr_i & (special_i | (window_open_i & ~blocked));
    val_d   = wdata_i & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= RST & IMPL;
      lock_q <= 1'b0;
    end else if (accept) begin
      val_q  <= val_d;
      lock_q <= 1'b1;
    end
  end

  assign q_o      = val_q;
  assign locked_o = lock_q;
endmodule

// File: rtl/pcb_map_decode.sv
module pcb_map_decode #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_W    = 4,
  parameter int RAM_BYTES = 256,
  parameter int REG_BYTES = 64
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PAGE_W-1:0] ram_page_i,
  input  logic [PAGE_W-1:0] reg_page_i,
  output logic              ram_sel_o,
  output logic              reg_sel_o
);
  localparam int OFF_W = ADDR_W - PAGE_W;
  localparam logic [OFF_W-1:0] RAM_LIM = OFF_W'(RAM_BYTES);
  localparam logic [OFF_W-1:0] REG_LIM = OFF_W'(REG_BYTES);

  logic [PAGE_W-1:0] page;
  logic [OFF_W-1:0]  offs;
  logic              ram_hit, reg_hit;

  always_comb begin
    page      = addr_i[ADDR_W-1 -: PAGE_W];
    offs      = addr_i[OFF_W-1:0];
    ram_hit   = (page == ram_page_i) && (offs < RAM_LIM);
    reg_hit   = (page == reg_page_i) && (offs < REG_LIM);
    reg_sel_o = reg_hit;
    ram_sel_o = ram_hit & ~reg_hit;
  end
endmodule

// File: rtl/prot_cfg_bank.sv
module prot_cfg_bank
  import pcb_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WINDOW    = 64,
  parameter int RAM_BYTES = 256,
  parameter int REG_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              special_strap_i,
  input  logic              cfg_sel_i,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              ram_sel_o,
  output logic              reg_sel_o,
  output logic              special_o,
  output logic              win_closed_o
);
  logic                               wr_en;
  logic                               win_open;
  logic                               exit_q, exit_d, exit_en;
  logic                               special;
  logic [NUM_PROT-1:0]                prot_wr;
  logic [NUM_PROT-1:0]                lock_v;
  logic [NUM_PROT-1:0][DATA_W-1:0]    prot_q;

  assign wr_en = cfg_sel_i & cfg_we_i;

  pcb_cycle_window #(.WINDOW(WINDOW)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .open_o (win_open)
  );

  // test mode: strap qualified by a one-way software exit
  always_comb begin
    exit_en = wr_en && (cfg_addr_i == SLOT_MODE) && !cfg_wdata_i[0];
    exit_d  = 1'b1;
    special = special_strap_i & ~exit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       exit_q <= 1'b0;
    else if (exit_en) exit_q <= exit_d;
  end

  for (genvar i = 0; i < NUM_PROT; i++) begin : g_prot
    assign prot_wr[i] = wr_en && (cfg_addr_i == SEL_W'(i));
    pcb_prot_reg #(
      .W    (DATA_W),
      .RST  (PROT_RST[i]),
      .IMPL (PROT_IMPL[i]),
      .ONCE (PROT_ONCE[i])
    ) u_reg (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_i          (prot_wr[i]),
      .window_open_i (win_open),
      .special_i     (special),
      .wdata_i       (cfg_wdata_i),
      .q_o           (prot_q[i]),
      .locked_o      (lock_v[i])
    );
  end

  always_comb begin
    unique case (cfg_addr_i)
      SLOT_MAP:  cfg_rdata_o = prot_q[0];
      SLOT_TCTL: cfg_rdata_o = prot_q[1];
      SLOT_OPT:  cfg_rdata_o = prot_q[2];
      default:   cfg_rdata_o = {{(DATA_W-1){1'b0}}, special};
    endcase
  end

  pcb_map_decode #(
    .ADDR_W    (ADDR_W),
    .PAGE_W    (PAGE_W),
    .RAM_BYTES (RAM_BYTES),
    .REG_BYTES (REG_BYTES)
  ) u_dec (
    .addr_i     (bus_addr_i),
    .ram_page_i (prot_q[0][DATA_W-1 -: PAGE_W]),
    .reg_page_i (prot_q[0][PAGE_W-1:0]),
    .ram_sel_o  (ram_sel_o),
    .reg_sel_o  (reg_sel_o)
  );

  assign special_o    = special;
  assign win_closed_o = ~win_open;
endmodule

// File: rtl/prot_cfg_bank_chk.sv
module prot_cfg_bank_chk
  import pcb_pkg::*;
(
  input logic                            clk,
  input logic                            rst_n,
  input logic                            cfg_sel_i,
  input logic                            cfg_we_i,
  input logic [SEL_W-1:0]                cfg_addr_i,
  input logic [DATA_W-1:0]               cfg_rdata_o,
  input logic                            ram_sel_o,
  input logic                            reg_sel_o,
  input logic                            special_o,
  input logic                            win_closed_o,
  input logic [NUM_PROT-1:0]             lock_v,
  input logic [NUM_PROT-1:0][DATA_W-1:0] prot_q
);
  logic wr;
  assign wr = cfg_sel_i & cfg_we_i;

  p_closed_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_closed_o |=> win_closed_o);

  p_late_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_closed_o && !special_o && wr && cfg_addr_i != SLOT_MODE) |=> $stable(prot_q));

  p_once_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_v[0] && !special_o && wr && cfg_addr_i == SLOT_MAP) |=> $stable(prot_q[0]));

  p_exit_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !special_o |=> !special_o);

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr_i == SLOT_TCTL) |-> (cfg_rdata_o[7:4] == 4'h0));

  p_single_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_sel_o && reg_sel_o));
endmodule

bind prot_cfg_bank prot_cfg_bank_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_sel_i    (cfg_sel_i),
  .cfg_we_i     (cfg_we_i),
  .cfg_addr_i   (cfg_addr_i),
  .cfg_rdata_o  (cfg_rdata_o),
  .ram_sel_o    (ram_sel_o),
  .reg_sel_o    (reg_sel_o),
  .special_o    (special_o),
  .win_closed_o (win_closed_o),
  .lock_v       (lock_v),
  .prot_q       (prot_q)
);

// File: tb/prot_cfg_bank_bench.sv
module prot_cfg_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wdata = 8'h00;
  logic [15:0] baddr = 16'h0000;
  wire  [7:0]  rdata;
  wire         ram_sel, reg_sel, special, win_closed;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ticks = 0;
  bit done = 1'b0;

  prot_cfg_bank u_prot_cfg_bank (
    .clk (clk), .rst_n (rst_n), .special_strap_i (strap),
    .cfg_sel_i (sel), .cfg_we_i (we), .cfg_addr_i (addr),
    .cfg_wdata_i (wdata), .cfg_rdata_o (rdata), .bus_addr_i (baddr),
    .ram_sel_o (ram_sel), .reg_sel_o (reg_sel), .special_o (special),
    .win_closed_o (win_closed)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // edges since reset release: at a falling edge, cyc is the index of the next edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  always @(posedge clk) begin
    ticks <= ticks + 1;
    if (ticks > WATCHDOG && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", ticks, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit s);
    @(negedge clk);
    rst_n = 1'b0; strap = s; sel = 1'b0; we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive a write so that it is sampled on edge n (or the next edge if later)
  task automatic write_at(input int n, input logic [1:0] a, input logic [7:0] d);
    while (cyc < n) @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic read_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
    addr = a;
    #1;
    check(rdata === exp, req, rdata, exp);
  endtask

  task automatic dec_chk(input logic [15:0] a, input bit exp_ram, input bit exp_reg, input string req);
    baddr = a;
    #1;
    check({ram_sel, reg_sel} === {exp_ram, exp_reg}, req, {ram_sel, reg_sel}, {exp_ram, exp_reg});
  endtask

  task automatic t_reset_state();
    do_reset(1'b0);
    read_chk(2'd0, 8'h01, "R1 map");
    read_chk(2'd1, 8'h00, "R1 tctl");
    read_chk(2'd2, 8'h10, "R1 opt");
    read_chk(2'd3, 8'h00, "R1 mode normal");
    check(win_closed === 1'b0, "R1 window", win_closed, 0);
    dec_chk(16'h1000, 1'b0, 1'b1, "R8 reset reg base");
    dec_chk(16'h103F, 1'b0, 1'b1, "R8 reg top");
    dec_chk(16'h1040, 1'b0, 1'b0, "R8 reg past end");
    dec_chk(16'h0000, 1'b1, 1'b0, "R7 reset ram base");
    dec_chk(16'h00FF, 1'b1, 1'b0, "R7 ram top");
    dec_chk(16'h0100, 1'b0, 1'b0, "R7 ram past end");
    do_reset(1'b1);
    read_chk(2'd3, 8'h01, "R1 mode special");
  endtask

  task automatic t_window_edges();
    do_reset(1'b0);
    write_at(10, 2'd2, 8'h11);
    write_at(20, 2'd2, 8'h22);
    read_chk(2'd2, 8'h22, "R3 opt rewritable");
    while (cyc < 63) @(negedge clk);
    check(win_closed === 1'b0, "R2 open at 63", win_closed, 0);
    write_at(63, 2'd2, 8'hAA);
    read_chk(2'd2, 8'hAA, "R2 write at edge 63");
    check(win_closed === 1'b1, "R2 closed after 63", win_closed, 1);
    write_at(64, 2'd2, 8'h5B);
    read_chk(2'd2, 8'hAA, "R2 write at edge 64 ignored");
    write_at(70, 2'd0, 8'h99);
    read_chk(2'd0, 8'h01, "R2 late map write ignored");
  endtask

  task automatic t_write_once();
    do_reset(1'b0);
    write_at(0, 2'd0, 8'h23);
    write_at(0, 2'd0, 8'h45);
    read_chk(2'd0, 8'h23, "R3 second map write ignored");
    write_at(0, 2'd1, 8'hFF);
    read_chk(2'd1, 8'h0F, "R6 upper nibble reads zero");
    write_at(0, 2'd1, 8'h03);
    read_chk(2'd1, 8'h0F, "R3 second tctl write ignored");
    read_chk(2'd1, 8'h0F, "R10 readback slot 1");
    sel = 1'b0; we = 1'b1; addr = 2'd2; wdata = 8'h77;
    @(negedge clk);
    we = 1'b0;
    read_chk(2'd2, 8'h10, "R10 no write without select");
    dec_chk(16'h2000, 1'b1, 1'b0, "R7 remapped ram base");
    dec_chk(16'h20FF, 1'b1, 1'b0, "R7 remapped ram top");
    dec_chk(16'h2100, 1'b0, 1'b0, "R7 remapped ram past end");
    dec_chk(16'h3000, 1'b0, 1'b1, "R8 remapped reg base");
    dec_chk(16'h303F, 1'b0, 1'b1, "R8 remapped reg top");
    dec_chk(16'h3040, 1'b0, 1'b0, "R8 remapped reg past end");
    dec_chk(16'h1000, 1'b0, 1'b0, "R8 old reg page dropped");
  endtask

  task automatic t_overlap();
    do_reset(1'b0);
    write_at(0, 2'd0, 8'h44);
    dec_chk(16'h4000, 1'b0, 1'b1, "R9 overlap reg wins");
    dec_chk(16'h403F, 1'b0, 1'b1, "R9 overlap reg top");
    dec_chk(16'h4080, 1'b1, 1'b0, "R9 ram beyond reg block");
  endtask

  task automatic t_special_mode();
    do_reset(1'b1);
    while (cyc < 100) @(negedge clk);
    check(win_closed === 1'b1, "R4 window closed", win_closed, 1);
    write_at(0, 2'd0, 8'h55);
    read_chk(2'd0, 8'h55, "R4 late write accepted");
    write_at(0, 2'd0, 8'h66);
    read_chk(2'd0, 8'h66, "R4 rewrite accepted");
    write_at(0, 2'd1, 8'h0A);
    write_at(0, 2'd1, 8'h0C);
    read_chk(2'd1, 8'h0C, "R4 tctl rewrite");
    write_at(0, 2'd3, 8'h01);
    read_chk(2'd3, 8'h01, "R5 writing one keeps mode");
    write_at(0, 2'd3, 8'h00);
    read_chk(2'd3, 8'h00, "R5 mode cleared");
    check(special === 1'b0, "R5 special low", special, 0);
    write_at(0, 2'd0, 8'h77);
    read_chk(2'd0, 8'h66, "R5 protection after exit");
    write_at(0, 2'd3, 8'h01);
    read_chk(2'd3, 8'h00, "R5 cannot re-enter");
  endtask

  task automatic t_exit_in_window();
    do_reset(1'b1);
    write_at(1, 2'd1, 8'h05);
    write_at(2, 2'd3, 8'h00);
    write_at(5, 2'd0, 8'h12);
    read_chk(2'd0, 8'h12, "R5 window write after exit");
    write_at(6, 2'd0, 8'h34);
    read_chk(2'd0, 8'h12, "R5 once applies after exit");
    write_at(7, 2'd1, 8'h09);
    read_chk(2'd1, 8'h05, "R5 test-mode write counts as first");
  endtask

  initial begin
    t_reset_state();
    t_window_edges();
    t_write_once();
    t_overlap();
    t_special_mode();
    t_exit_in_window();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule